// File: doc/BRIEF.md
# Hibernate Power Sequencer

This block supervises a programmable logic device that loses its configuration when power is removed. It takes the device into a deep low-power state and brings it back out again. On a hibernate request it holds the device's configuration reset low, which floats all device I/Os. It then waits until the device has pulled both its initialization line and its completion line low. Only then does it switch off the core and auxiliary supplies. An I/O bank supply may also be dropped, but only while the surrounding system marks that bank as quiet, meaning its pins are held low or the external drivers are off. The internal pull-ups are kept disabled everywhere outside normal operation.

On a wake request, every switched supply is turned back on in parallel. The configuration reset is released only after the core, the auxiliary and every bank supply report good. The block then waits for the device's open-drain initialization line to rise, and after that for the completion line. Only then does it declare the device operational. Both device lines pass through a two-flop synchronizer and a stability filter before the state machine uses them. Every waiting step is bounded by its own programmable cycle limit. A step that runs out of time parks the block in a fault state and records a sticky code that names the step.

The states are IDLE_ON, ASSERT_PROG, WAIT_LOW, RAILS_OFF, HIBERNATE, RAILS_ON, RELEASE_PROG, WAIT_INIT, WAIT_DONE, READY and ERROR. The transitions are:
- IDLE_ON goes to RAILS_ON unconditionally.
- READY goes to ASSERT_PROG on a hibernate request.
- ASSERT_PROG goes to WAIT_LOW unconditionally.
- WAIT_LOW goes to RAILS_OFF when both filtered lines are low.
- RAILS_OFF goes to HIBERNATE when the core and auxiliary good flags are both low.
- HIBERNATE goes to RAILS_ON on a wake request, either live or latched.
- RAILS_ON goes to RELEASE_PROG when every supply is good.
- RELEASE_PROG goes to WAIT_INIT unconditionally.
- WAIT_INIT goes to WAIT_DONE when the filtered initialization line is high.
- WAIT_DONE goes to READY when the filtered completion line is high.
- Any of WAIT_LOW, RAILS_OFF, RAILS_ON, WAIT_INIT and WAIT_DONE goes to ERROR when its limit expires.

Top module: `hib_seq_ctrl`

## Requirements
- R1: While reset is asserted and in the first state after it (IDLE_ON), the configuration reset output is low. The core, auxiliary and all bank enables are high. ready_o, hib_o and error_o are low and fault_o is 0. The block then runs the power-up sequence to READY without any request.
- R2: After a hibernate request in READY, the configuration reset output goes low before any supply enable drops. It stays low for as long as any supply enable is low.
- R3: The core and auxiliary enables drop only after both filtered device lines are low. hib_o rises once the core and auxiliary good flags are both low.
- R4: Bank enable b is low only while the block is in RAILS_OFF or HIBERNATE and bank_quiet_i[b] is 1. In every other case, including when the flag is cleared during hibernation, it is high.
- R5: pullup_dis_o is high in every state except READY.
- R6: On wake, all enables go high. The configuration reset output rises only after pg_core_i, pg_aux_i and every bit of pg_bank_i were high.
- R7: After release, the block waits for the filtered initialization line to go high, and then for the filtered completion line. Only then does ready_o rise. The configuration reset output stays high throughout READY.
- R8: A wake request seen in ASSERT_PROG, WAIT_LOW or RAILS_OFF is remembered and honoured on reaching HIBERNATE. A wake request in READY has no effect and is not remembered.
- R9: A hibernate request in any state other than READY has no effect.
- R10: A device line change is accepted only after the synchronized level has differed from the accepted level for FILT_CYC consecutive cycles. A shorter pulse is ignored.
- R11: When a wait step exceeds its limit, the block enters ERROR and sets fault_o to the code for that step: 1 for WAIT_LOW, 2 for RAILS_OFF, 3 for RAILS_ON, 4 for WAIT_INIT, 5 for WAIT_DONE.
- R12: ERROR holds until reset. In ERROR, error_o is 1, fault_o is unchanged, the configuration reset output is low, all enables are high and ready_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hib_req_i | input | 1 | Request to enter hibernation |
| wake_req_i | input | 1 | Request to leave hibernation |
| pg_core_i | input | 1 | Core supply good |
| pg_aux_i | input | 1 | Auxiliary supply good |
| pg_bank_i | input | NBANK | Per-bank I/O supply good |
| bank_quiet_i | input | NBANK | Bank pins held low or external drivers off; bank may be unpowered |
| init_line_i | input | 1 | Device initialization line (open drain, high = initialized) |
| done_line_i | input | 1 | Device completion line (high = configured) |
| tmo_low_i | input | TW | Cycle limit for WAIT_LOW |
| tmo_off_i | input | TW | Cycle limit for RAILS_OFF |
| tmo_on_i | input | TW | Cycle limit for RAILS_ON |
| tmo_init_i | input | TW | Cycle limit for WAIT_INIT |
| tmo_done_i | input | TW | Cycle limit for WAIT_DONE |
| dev_cfg_rst_n_o | output | 1 | Device configuration reset, low = held in reset |
| pullup_dis_o | output | 1 | Disable device internal pull-ups |
| en_core_o | output | 1 | Core supply enable |
| en_aux_o | output | 1 | Auxiliary supply enable |
| en_bank_o | output | NBANK | Per-bank I/O supply enable |
| ready_o | output | 1 | Device operational |
| hib_o | output | 1 | Device hibernating |
| error_o | output | 1 | Sequencing fault |
| fault_o | output | 3 | Sticky fault code |

## Verification
The assertions take for granted that the supply good flags follow the enables, that they are driven from the same clock domain, and that none of them changes in the cycle the block reacts to it. They also assume the device lines fall only while the configuration reset is held low. The bench meets these assumptions with a behavioural device model. In that model, each supply good flag follows its enable with a fixed delay. The device lines drop a few cycles after the reset goes low and rise in order after it is released. All inputs change on the falling clock edge. Fault cases are produced by knobs that stall one model response or pin one flag.

// File: rtl/hib_pkg.sv
`timescale 1ns/1ps
package hib_pkg;

    typedef enum logic [3:0] {
        ST_IDLE_ON      = 4'd0,
        ST_ASSERT_PROG  = 4'd1,
        ST_WAIT_LOW     = 4'd2,
        ST_RAILS_OFF    = 4'd3,
        ST_HIBERNATE    = 4'd4,
        ST_RAILS_ON     = 4'd5,
        ST_RELEASE_PROG = 4'd6,
        ST_WAIT_INIT    = 4'd7,
        ST_WAIT_DONE    = 4'd8,
        ST_READY        = 4'd9,
        ST_ERROR        = 4'd10
    } hib_state_e;

    typedef enum logic [2:0] {
        FLT_NONE = 3'd0,
        FLT_LOW  = 3'd1,
        FLT_OFF  = 3'd2,
        FLT_ON   = 3'd3,
        FLT_INIT = 3'd4,
        FLT_DONE = 3'd5
    } hib_fault_e;

endpackage

// File: rtl/hib_line_filt.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by a stability filter on one device line.
module hib_line_filt #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic          sync1_q, sync2_q, lvl_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            lvl_q   <= 1'b0;
            run_q   <= '0;
        end else begin
            sync1_q <= line_i;
            sync2_q <= sync1_q;
            if (sync2_q == lvl_q) begin
                run_q <= '0;
            end else if (run_q == LAST) begin
                lvl_q <= sync2_q;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign level_o = lvl_q;
endmodule

// File: rtl/hib_tmo_cnt.sv
`timescale 1ns/1ps
// Step timer: cleared on every state change, saturates at the limit.
module hib_tmo_cnt #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [TW-1:0] lim_i,
    output logic          exp_o
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != lim_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign exp_o = (cnt_q == lim_i);
endmodule

// File: rtl/hib_bank_gate.sv
`timescale 1ns/1ps
// Per-bank supply gating: a bank is unpowered only in the off zone and while quiet.
module hib_bank_gate #(
    parameter int NBANK = 4
) (
    input  logic             off_zone_i,
    input  logic [NBANK-1:0] quiet_i,
    output logic [NBANK-1:0] en_o
);
    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign en_o[b] = !(off_zone_i && quiet_i[b]);
        end
    endgenerate
endmodule

// File: rtl/hib_seq_ctrl.sv
`timescale 1ns/1ps
module hib_seq_ctrl
    import hib_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int TW       = 16,
    parameter int FILT_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hib_req_i,
    input  logic             wake_req_i,
    input  logic             pg_core_i,
    input  logic             pg_aux_i,
    input  logic [NBANK-1:0] pg_bank_i,
    input  logic [NBANK-1:0] bank_quiet_i,
    input  logic             init_line_i,
    input  logic             done_line_i,
    input  logic [TW-1:0]    tmo_low_i,
    input  logic [TW-1:0]    tmo_off_i,
    input  logic [TW-1:0]    tmo_on_i,
    input  logic [TW-1:0]    tmo_init_i,
    input  logic [TW-1:0]    tmo_done_i,
    output logic             dev_cfg_rst_n_o,
    output logic             pullup_dis_o,
    output logic             en_core_o,
    output logic             en_aux_o,
    output logic [NBANK-1:0] en_bank_o,
    output logic             ready_o,
    output logic             hib_o,
    output logic             error_o,
    output logic [2:0]       fault_o
);
    localparam int NLINE     = 2;
    localparam int LINE_INIT = 0;
    localparam int LINE_DONE = 1;

    // Device line conditioning
    logic [NLINE-1:0] raw_lines, filt_lines;
    logic             init_f, done_f;

    assign raw_lines = {done_line_i, init_line_i};

    generate
        for (genvar g = 0; g < NLINE; g++) begin : g_filt
            hib_line_filt #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .line_i  (raw_lines[g]),
                .level_o (filt_lines[g])
            );
        end
    endgenerate

    assign init_f = filt_lines[LINE_INIT];
    assign done_f = filt_lines[LINE_DONE];

    // Supply status
    logic rails_good, rails_down;
    assign rails_good = pg_core_i && pg_aux_i && (&pg_bank_i);
    assign rails_down = !pg_core_i && !pg_aux_i;

    // State, fault and wake latch
    hib_state_e state_q, state_d;
    hib_fault_e fault_q, fault_d;
    logic       wake_pend_q, wake_go, in_entry;
    logic       tmo_exp, tmo_clr;
    logic [TW-1:0] tmo_lim;

    assign in_entry = (state_q == ST_ASSERT_PROG) || (state_q == ST_WAIT_LOW) ||
                      (state_q == ST_RAILS_OFF);
    assign wake_go  = wake_req_i || wake_pend_q;
    assign tmo_clr  = (state_d != state_q);

    // Limit for the step currently waiting
    always_comb begin
        unique case (state_q)
            ST_WAIT_LOW:  tmo_lim = tmo_low_i;
            ST_RAILS_OFF: tmo_lim = tmo_off_i;
            ST_RAILS_ON:  tmo_lim = tmo_on_i;
            ST_WAIT_INIT: tmo_lim = tmo_init_i;
            ST_WAIT_DONE: tmo_lim = tmo_done_i;
            default:      tmo_lim = '1;
        endcase
    end

    hib_tmo_cnt #(.TW(TW)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tmo_clr),
        .lim_i (tmo_lim),
        .exp_o (tmo_exp)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        fault_d = FLT_NONE;
        unique case (state_q)
            ST_IDLE_ON:      state_d = ST_RAILS_ON;
            ST_READY:        if (hib_req_i) state_d = ST_ASSERT_PROG;
            ST_ASSERT_PROG:  state_d = ST_WAIT_LOW;
            ST_WAIT_LOW: begin
                if (!init_f && !done_f) begin
                    state_d = ST_RAILS_OFF;
                end else if (tmo_exp) begin
                    state_d = ST_ERROR;
                    fault_d = FLT_LOW;
                end
            end
            ST_RAILS_OFF: begin
                if (rails_down) begin
                    state_d = ST_HIBERNATE;
                end else if (tmo_exp) begin
                    state_d = ST_ERROR;
                    fault_d = FLT_OFF;
                end
            end
            ST_HIBERNATE:    if (wake_go) state_d = ST_RAILS_ON;
            ST_RAILS_ON: begin
                if (rails_good) begin
                    state_d = ST_RELEASE_PROG;
                end else if (tmo_exp) begin
                    state_d = ST_ERROR;
                    fault_d = FLT_ON;
                end
            end
            ST_RELEASE_PROG: state_d = ST_WAIT_INIT;
            ST_WAIT_INIT: begin
                if (init_f) begin
                    state_d = ST_WAIT_DONE;
                end else if (tmo_exp) begin
                    state_d = ST_ERROR;
                    fault_d = FLT_INIT;
                end
            end
            ST_WAIT_DONE: begin
                if (done_f) begin
                    state_d = ST_READY;
                end else if (tmo_exp) begin
                    state_d = ST_ERROR;
                    fault_d = FLT_DONE;
                end
            end
            ST_ERROR:        state_d = ST_ERROR;
            default:         state_d = ST_ERROR;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE_ON;
            fault_q     <= FLT_NONE;
            wake_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_ERROR && state_d == ST_ERROR) begin
                fault_q <= fault_d;
            end
            if (state_q == ST_HIBERNATE) begin
                wake_pend_q <= 1'b0;
            end else if (in_entry && wake_req_i) begin
                wake_pend_q <= 1'b1;
            end
        end
    end

    // Outputs
    logic off_zone;

    always_comb begin
        dev_cfg_rst_n_o = 1'b0;
        en_core_o       = 1'b1;
        en_aux_o        = 1'b1;
        off_zone        = 1'b0;
        pullup_dis_o    = 1'b1;
        ready_o         = 1'b0;
        hib_o           = 1'b0;
        error_o         = 1'b0;
        unique case (state_q)
            ST_RAILS_OFF: begin
                en_core_o = 1'b0;
                en_aux_o  = 1'b0;
                off_zone  = 1'b1;
            end
            ST_HIBERNATE: begin
                en_core_o = 1'b0;
                en_aux_o  = 1'b0;
                off_zone  = 1'b1;
                hib_o     = 1'b1;
            end
            ST_RELEASE_PROG, ST_WAIT_INIT, ST_WAIT_DONE: begin
                dev_cfg_rst_n_o = 1'b1;
            end
            ST_READY: begin
                dev_cfg_rst_n_o = 1'b1;
                pullup_dis_o    = 1'b0;
                ready_o         = 1'b1;
            end
            ST_ERROR:  error_o = 1'b1;
            default: ;
        endcase
    end

    hib_bank_gate #(.NBANK(NBANK)) u_bank (
        .off_zone_i (off_zone),
        .quiet_i    (bank_quiet_i),
        .en_o       (en_bank_o)
    );

    assign fault_o = fault_q;
endmodule

// File: rtl/hib_seq_chk.sv
`timescale 1ns/1ps
module hib_seq_chk #(
    parameter int NBANK = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_rst_n,
    input logic             pullup_dis,
    input logic             en_core,
    input logic             en_aux,
    input logic [NBANK-1:0] en_bank,
    input logic [NBANK-1:0] bank_quiet,
    input logic             pg_core,
    input logic             pg_aux,
    input logic [NBANK-1:0] pg_bank,
    input logic             init_f,
    input logic             done_f,
    input logic             ready,
    input logic             error,
    input logic [2:0]       fault
);
    assert_reset_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_core || !en_aux) |-> !cfg_rst_n);

    assert_rails_after_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_core) |-> $past(!init_f && !done_f));

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank_chk
            assert_bank_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !en_bank[b] |-> bank_quiet[b]);
        end
    endgenerate

    assert_pullup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pullup_dis |-> ready);

    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_rst_n) |-> $past(pg_core && pg_aux && (&pg_bank)));

    assert_ready_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(done_f));

    assert_ready_out_of_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> cfg_rst_n);

    assert_fault_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (fault != 3'd0 && fault <= 3'd5));

    assert_error_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> (error && $stable(fault)));
endmodule

bind hib_seq_ctrl hib_seq_chk #(.NBANK(NBANK)) u_hib_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_rst_n  (dev_cfg_rst_n_o),
    .pullup_dis (pullup_dis_o),
    .en_core    (en_core_o),
    .en_aux     (en_aux_o),
    .en_bank    (en_bank_o),
    .bank_quiet (bank_quiet_i),
    .pg_core    (pg_core_i),
    .pg_aux     (pg_aux_i),
    .pg_bank    (pg_bank_i),
    .init_f     (init_f),
    .done_f     (done_f),
    .ready      (ready_o),
    .error      (error_o),
    .fault      (fault_o)
);

// File: tb/hib_seq_ctrl_tb.sv
`timescale 1ns/1ps
module hib_seq_ctrl_tb;
    localparam int NB  = 4;
    localparam int TWB = 16;
    localparam int EV_READY = 16;
    localparam int EV_HIB   = 32;
    localparam int EV_ERR   = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, hib_req, wake_req, pg_core, pg_aux, m_init, m_done;
    logic [NB-1:0] pg_bank, quiet;
    logic [TWB-1:0] t_low, t_off, t_on, t_init, t_done;
    logic cfg_rst_n, pullup_dis, en_core, en_aux, ready, hib, error;
    logic [NB-1:0] en_bank;
    logic [2:0] fault;

    hib_seq_ctrl #(.NBANK(NB), .TW(TWB), .FILT_CYC(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .hib_req_i(hib_req), .wake_req_i(wake_req),
        .pg_core_i(pg_core), .pg_aux_i(pg_aux), .pg_bank_i(pg_bank),
        .bank_quiet_i(quiet), .init_line_i(m_init), .done_line_i(m_done),
        .tmo_low_i(t_low), .tmo_off_i(t_off), .tmo_on_i(t_on),
        .tmo_init_i(t_init), .tmo_done_i(t_done),
        .dev_cfg_rst_n_o(cfg_rst_n), .pullup_dis_o(pullup_dis),
        .en_core_o(en_core), .en_aux_o(en_aux), .en_bank_o(en_bank),
        .ready_o(ready), .hib_o(hib), .error_o(error), .fault_o(fault)
    );

    int n_chk = 0;
    int n_err = 0;
    int exp_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input int code);
        exp_q.push_back(code);
    endtask

    task automatic observe(input int code);
        int e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R7 R11 unexpected event", code, 0);
        end else begin
            e = exp_q.pop_front();
            check(e == code, "R1 R7 R11 scoreboard event", code, e);
        end
    endtask

    task automatic wait_drain(input int max, input string tag);
        for (int i = 0; i < max && exp_q.size() != 0; i++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    // Device and power model knobs
    bit stall_low, stall_init, stall_done, glitch_done, pg_lo, pg_hi;
    int lc, hc, cdly;

    task automatic clear_knobs();
        stall_low = 0; stall_init = 0; stall_done = 0;
        glitch_done = 0; pg_lo = 0; pg_hi = 0;
    endtask

    initial begin
        m_init = 1'b0; m_done = 1'b0; pg_core = 1'b0; pg_aux = 1'b0; pg_bank = '0;
        lc = 0; hc = 0; cdly = 0;
        forever begin
            @(negedge clk);
            if (!en_core) cdly = 0;
            else if (cdly < 5) cdly++;
            pg_core = pg_hi ? 1'b1 : (pg_lo ? 1'b0 : (cdly == 5));
            pg_aux  = en_aux;
            pg_bank = en_bank;
            if (!(pg_core && pg_aux)) begin
                m_init = 1'b0; m_done = 1'b0; lc = 0; hc = 0;
            end else if (!cfg_rst_n) begin
                hc = 0; lc++;
                if (lc >= 3 && !stall_low) begin
                    m_init = 1'b0; m_done = 1'b0;
                end
            end else begin
                lc = 0; hc++;
                m_init = !stall_init && hc >= 4;
                m_done = (!stall_done && hc >= 12) || (glitch_done && hc == 8);
            end
        end
    end

    // Monitor: event scoreboard and ordering checks
    initial begin
        logic p_ready, p_hib, p_err, p_core, p_cfg;
        p_ready = 0; p_hib = 0; p_err = 0; p_core = 1; p_cfg = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (ready && !p_ready) observe(EV_READY);
                if (hib && !p_hib)     observe(EV_HIB);
                if (error && !p_err)   observe(EV_ERR + int'(fault));
                if (!en_core && p_core)
                    check(!m_init && !m_done, "R3 lines low at rail removal",
                          int'({m_init, m_done}), 0);
                if (cfg_rst_n && !p_cfg)
                    check(pg_core && pg_aux && (&pg_bank), "R6 supplies good at release",
                          int'({pg_core, pg_aux, pg_bank}), (1 << (NB + 2)) - 1);
            end
            p_ready = ready; p_hib = hib; p_err = error; p_core = en_core; p_cfg = cfg_rst_n;
        end
    end

    task automatic pulse_hib();
        @(negedge clk) hib_req = 1'b1;
        @(negedge clk) hib_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk) wake_req = 1'b1;
        @(negedge clk) wake_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        clear_knobs();
        rst_n = 1'b0; hib_req = 1'b0; wake_req = 1'b0; quiet = '0;
        t_low = 16'd40; t_off = 16'd40; t_on = 16'd40; t_init = 16'd40; t_done = 16'd40;
        repeat (3) @(negedge clk);

        // R1 reset state
        check(cfg_rst_n == 0, "R1 reset cfg", cfg_rst_n, 0);
        check(en_core && en_aux && en_bank == '1, "R1 reset enables",
              int'({en_core, en_aux, en_bank}), 63);
        check(!ready && !hib && !error && fault == 0, "R1 reset flags",
              int'({ready, hib, error, fault}), 0);
        check(pullup_dis == 1, "R5 pullup in reset", pullup_dis, 1);
        expect_ev(EV_READY);
        rst_n = 1'b1;
        wait_drain(300, "R1 boot to ready");
        check(cfg_rst_n == 1 && pullup_dis == 0, "R5 R7 ready outputs",
              int'({cfg_rst_n, pullup_dis}), 2);

        // R8 wake ignored in READY
        pulse_wake();
        repeat (20) @(negedge clk);
        check(ready == 1 && en_core == 1, "R8 wake in ready ignored", ready, 1);

        // Hibernate entry with two quiet banks
        quiet = 4'b0101;
        expect_ev(EV_HIB);
        pulse_hib();
        wait_drain(300, "R2 R3 enter hibernate");
        repeat (30) @(negedge clk);
        check(hib == 1, "R8 no stale wake remembered", hib, 1);
        check(!en_core && !en_aux, "R3 core aux off", int'({en_core, en_aux}), 0);
        check(en_bank == 4'b1010, "R4 quiet banks off", en_bank, 4'b1010);
        check(pullup_dis == 1 && cfg_rst_n == 0, "R2 R5 hibernate pins",
              int'({pullup_dis, cfg_rst_n}), 2);
        quiet = 4'b0000;
        @(negedge clk);
        check(en_bank == 4'b1111, "R4 flag cleared repowers bank", en_bank, 4'b1111);
        quiet = 4'b0101;

        // R9 hibernate request in HIBERNATE ignored
        pulse_hib();
        repeat (10) @(negedge clk);
        check(hib == 1 && en_core == 0, "R9 hib request ignored", hib, 1);

        // Wake
        expect_ev(EV_READY);
        pulse_wake();
        wait_drain(300, "R6 R7 wake to ready");

        // R8 wake during entry is latched
        expect_ev(EV_HIB);
        expect_ev(EV_READY);
        pulse_hib();
        pulse_wake();
        wait_drain(400, "R8 latched wake");
        quiet = '0;

        // R10 short pulse on completion line ignored
        clear_knobs();
        t_done = 16'd200; stall_done = 1; glitch_done = 1;
        do_reset();
        repeat (80) @(negedge clk);
        check(ready == 0 && error == 0, "R10 glitch ignored", int'({ready, error}), 0);
        expect_ev(EV_READY);
        stall_done = 0;
        wait_drain(300, "R10 real completion accepted");
        t_done = 16'd40;

        // R11 supply-on timeout and R12 stickiness
        clear_knobs(); pg_lo = 1;
        expect_ev(EV_ERR + 3);
        do_reset();
        wait_drain(300, "R11 rails on timeout");
        pg_lo = 0;
        repeat (20) @(negedge clk);
        check(error == 1 && fault == 3, "R12 error sticky", int'(fault), 3);
        check(cfg_rst_n == 0 && ready == 0, "R12 error pins", int'({cfg_rst_n, ready}), 0);
        check(en_core && en_aux && en_bank == '1, "R12 error enables",
              int'({en_core, en_aux, en_bank}), 63);

        clear_knobs(); stall_init = 1;
        expect_ev(EV_ERR + 4);
        do_reset();
        wait_drain(300, "R11 init timeout");

        clear_knobs(); stall_done = 1;
        expect_ev(EV_ERR + 5);
        do_reset();
        wait_drain(300, "R11 done timeout");

        clear_knobs();
        expect_ev(EV_READY);
        do_reset();
        wait_drain(300, "R1 reboot");
        stall_low = 1;
        expect_ev(EV_ERR + 1);
        pulse_hib();
        wait_drain(300, "R11 lines low timeout");

        clear_knobs();
        expect_ev(EV_READY);
        do_reset();
        wait_drain(300, "R1 reboot");
        pg_hi = 1;
        expect_ev(EV_ERR + 2);
        pulse_hib();
        wait_drain(300, "R11 rails off timeout");

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule